// File: doc/BRIEF.md
# Remote Update Parameter Access Port

This block is the register front end through which user logic inspects and changes the settings used for remote reconfiguration of the device. It keeps two local sets of settings. The update set is staged by the user for the next reconfiguration. The control set holds the settings currently in force. A 3-bit parameter select picks a field. Single-cycle read and write strobes start an access, and a busy output covers the access for a fixed number of cycles. Read data appears on the output in the same edge that busy drops.

A reconfiguration request copies the update set into the control set and records that the fabric triggered the reload. Writes only take effect while the control set says the factory image is running. A select line chooses which set a read returns. Shifting the registers into dedicated silicon is not part of this block.

Top module: `rup_param_port`

## Requirements
- R1: After reset, busy is 0, the read data output is 0, both register sets are all zero, the reason field is 0 and the mode is factory (mode bit 0).
- R2: A read or write strobe sampled high while busy is low raises busy on the next cycle, and busy then stays high for exactly BUSY_CYC cycles.
- R3: While busy is high, the strobes and the reconfiguration request are ignored. Changes on the select, data and source inputs do not alter the access in progress.
- R4: The read data output changes only at the clock edge where a read completes (the edge where busy falls), and it holds that value until the next read completes.
- R5: The source input is sampled together with the strobe: 1 returns the control set and 0 returns the update set.
- R6: The select codes are timeout 3'b010, enable 3'b011 and mode 3'b101. The timeout uses data bits [11:0], and enable and mode use bit [0]. Reads return these fields zero-extended.
- R7: The page code 3'b100 stores data bits [31:2]. A read returns that value with bits [1:0] zero.
- R8: The status code 3'b000 is read-only. It returns the reason field in bits [4:0] from either source. After a fabric-triggered reconfiguration the reason reads 5'b00010.
- R9: The codes 3'b001, 3'b110 and 3'b111 are illegal. Accesses to them complete with normal busy timing, reads return 0, and writes change nothing.
- R10: A write changes the update set only while the control mode bit is 0. Once an application image is current, writes are dropped.
- R11: A reconfiguration request sampled while busy is low copies the update set into the control set at that edge.
- R12: If both strobes are high in the same accepted cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high asynchronous reset |
| prm_sel | input | 3 | Parameter select code |
| prm_din | input | 32 | Write data |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| reconf_req | input | 1 | Reconfiguration request |
| rd_from_ctl | input | 1 | Read source: 1 selects the control set, 0 selects the update set |
| busy | output | 1 | Access in progress |
| prm_dout | output | 32 | Read data, valid once busy is low |

## Verification
The bench builds the block with BUSY_CYC = 3 rather than the default of 4. With that value it can strike the strobes, the request and the select, data and source lines partway through a busy window and then still see the window end on the expected edge. This also shows that the busy length follows the parameter rather than a fixed count. The bench then moves the block into application mode through two reconfigurations, which brings the write lockout within reach.

// File: rtl/rup_pkg.sv
package rup_pkg;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 3;
  localparam int TMO_W    = 12;
  localparam int PAGE_W   = 30;
  localparam int REASON_W = 5;
  localparam logic [REASON_W-1:0] REASON_CORE = 5'b00010;

  typedef enum logic [SEL_W-1:0] {
    P_STATUS = 3'b000,
    P_BAD1   = 3'b001,
    P_TMO    = 3'b010,
    P_WDEN   = 3'b011,
    P_PAGE   = 3'b100,
    P_MODE   = 3'b101,
    P_BAD6   = 3'b110,
    P_BAD7   = 3'b111
  } rup_sel_e;

  typedef struct packed {
    logic [TMO_W-1:0]  tmo;
    logic              wden;
    logic [PAGE_W-1:0] page;
    logic              mode;
  } rup_cfg_t;

  function automatic logic sel_legal(input logic [SEL_W-1:0] s);
    case (rup_sel_e'(s))
      P_STATUS, P_TMO, P_WDEN, P_PAGE, P_MODE: sel_legal = 1'b1;
      default:                                 sel_legal = 1'b0;
    endcase
  endfunction

  function automatic rup_cfg_t apply_write(input rup_cfg_t c,
                                           input logic [SEL_W-1:0] s,
                                           input logic [DATA_W-1:0] d);
    rup_cfg_t n;
    n = c;
    case (rup_sel_e'(s))
      P_TMO:   n.tmo  = d[TMO_W-1:0];
      P_WDEN:  n.wden = d[0];
      P_PAGE:  n.page = d[DATA_W-1 -: PAGE_W];
      P_MODE:  n.mode = d[0];
      default: n = c;
    endcase
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] read_field(input rup_cfg_t c,
                                                   input logic [REASON_W-1:0] rsn,
                                                   input logic [SEL_W-1:0] s);
    logic [DATA_W-1:0] v;
    case (rup_sel_e'(s))
      P_STATUS: v = DATA_W'(rsn);
      P_TMO:    v = DATA_W'(c.tmo);
      P_WDEN:   v = DATA_W'(c.wden);
      P_PAGE:   v = {c.page, {(DATA_W-PAGE_W){1'b0}}};
      P_MODE:   v = DATA_W'(c.mode);
      default:  v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rup_seq.sv
module rup_seq
  import rup_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  input  logic              src,
  output logic              busy,
  output logic              op_done,
  output logic              op_is_rd,
  output logic [SEL_W-1:0]  op_sel,
  output logic [DATA_W-1:0] op_din,
  output logic              op_src
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign busy    = (cnt != '0);
  assign accept  = !busy && (rd_stb || wr_stb);
  assign op_done = (cnt == CNT_W'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      op_is_rd <= 1'b0;
      op_sel   <= '0;
      op_din   <= '0;
      op_src   <= 1'b0;
    end else if (accept) begin
      cnt      <= CNT_LOAD;
      op_is_rd <= rd_stb;
      op_sel   <= sel;
      op_din   <= din;
      op_src   <= src;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !busy);
  // R3
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> ($stable(op_sel) && $stable(op_din) &&
                                $stable(op_is_rd) && $stable(op_src)));
endmodule

// File: rtl/rup_regs.sv
module rup_regs
  import rup_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_commit,
  input  logic [SEL_W-1:0]    sel,
  input  logic [DATA_W-1:0]   din,
  input  logic                reconf,
  output rup_cfg_t            upd_cfg,
  output rup_cfg_t            ctl_cfg,
  output logic [REASON_W-1:0] ctl_reason
);
  logic wr_en;
  assign wr_en = wr_commit && !ctl_cfg.mode;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      upd_cfg <= '0;
    end else if (wr_en) begin
      upd_cfg <= apply_write(upd_cfg, sel, din);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctl_cfg    <= '0;
      ctl_reason <= '0;
    end else if (reconf) begin
      ctl_cfg    <= upd_cfg;
      ctl_reason <= REASON_CORE;
    end
  end

  // R10
  app_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && ctl_cfg.mode) |=> $stable(upd_cfg));
  // R9
  bad_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !sel_legal(sel)) |=> $stable(upd_cfg));
  // R11
  reconf_copy_chk: assert property (@(posedge clk) disable iff (rst)
    reconf |=> (ctl_cfg == $past(upd_cfg)) && (ctl_reason == REASON_CORE));
  // R11
  ctl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !reconf |=> $stable(ctl_cfg) && $stable(ctl_reason));
endmodule

// File: rtl/rup_rdmux.sv
module rup_rdmux
  import rup_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_done,
  input  logic [SEL_W-1:0]    sel,
  input  logic                src,
  input  rup_cfg_t            upd_cfg,
  input  rup_cfg_t            ctl_cfg,
  input  logic [REASON_W-1:0] ctl_reason,
  output logic [DATA_W-1:0]   dout
);
  rup_cfg_t pick;
  assign pick = src ? ctl_cfg : upd_cfg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dout <= '0;
    end else if (rd_done) begin
      dout <= read_field(pick, ctl_reason, sel);
    end
  end

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> $stable(dout));
  // R9
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !sel_legal(sel)) |=> (dout == '0));
endmodule

// File: rtl/rup_param_port.sv
module rup_param_port
  import rup_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  prm_sel,
  input  logic [DATA_W-1:0] prm_din,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              reconf_req,
  input  logic              rd_from_ctl,
  output logic              busy,
  output logic [DATA_W-1:0] prm_dout
);
  logic                op_done, op_is_rd, op_src;
  logic [SEL_W-1:0]    op_sel;
  logic [DATA_W-1:0]   op_din;
  logic                rd_done, wr_commit, reconf;
  rup_cfg_t            upd_cfg, ctl_cfg;
  logic [REASON_W-1:0] ctl_reason;

  rup_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .sel(prm_sel), .din(prm_din), .src(rd_from_ctl),
    .busy(busy), .op_done(op_done), .op_is_rd(op_is_rd),
    .op_sel(op_sel), .op_din(op_din), .op_src(op_src)
  );

  assign rd_done   = op_done && op_is_rd;
  assign wr_commit = op_done && !op_is_rd;
  assign reconf    = reconf_req && !busy;

  rup_regs u_regs (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .sel(op_sel),
    .din(op_din), .reconf(reconf), .upd_cfg(upd_cfg),
    .ctl_cfg(ctl_cfg), .ctl_reason(ctl_reason)
  );

  rup_rdmux u_rdmux (
    .clk(clk), .rst(rst), .rd_done(rd_done), .sel(op_sel),
    .src(op_src), .upd_cfg(upd_cfg), .ctl_cfg(ctl_cfg),
    .ctl_reason(ctl_reason), .dout(prm_dout)
  );

  // R3
  busy_no_reconf_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctl_cfg));
  // R4
  dout_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(prm_dout) |-> $fell(busy));
endmodule

// File: tb/sim_rup_param_port.sv
module sim_rup_param_port;
  localparam int BC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  prm_sel = '0;
  logic [31:0] prm_din = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, reconf_req = 1'b0, rd_from_ctl = 1'b0;
  logic        busy;
  logic [31:0] prm_dout;

  int n_run = 0, n_fail = 0, bcnt = 0, cyc = 0;
  bit prev_busy = 1'b0;

  bit          q_rd[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  // bench model of the two register sets
  logic [11:0] u_tmo = '0, c_tmo = '0;
  logic        u_en = 0, c_en = 0, u_mode = 0, c_mode = 0;
  logic [29:0] u_page = '0, c_page = '0;
  logic [4:0]  m_reason = '0;

  rup_param_port #(.BUSY_CYC(BC)) u0 (
    .clk(clk), .rst(rst), .prm_sel(prm_sel), .prm_din(prm_din),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reconf_req(reconf_req),
    .rd_from_ctl(rd_from_ctl), .busy(busy), .prm_dout(prm_dout)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fexp(input logic [2:0] s, input bit src);
    case (s)
      3'b000: return {27'd0, m_reason};
      3'b010: return {20'd0, src ? c_tmo : u_tmo};
      3'b011: return {31'd0, src ? c_en : u_en};
      3'b100: return {src ? c_page : u_page, 2'b00};
      3'b101: return {31'd0, src ? c_mode : u_mode};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(input logic [2:0] s, input logic [31:0] d);
    if (c_mode) return;
    case (s)
      3'b010: u_tmo = d[11:0];
      3'b011: u_en = d[0];
      3'b100: u_page = d[31:2];
      3'b101: u_mode = d[0];
      default: ;
    endcase
  endtask

  task automatic push(input bit rd, input logic [31:0] e, input string tag);
    q_rd.push_back(rd); q_exp.push_back(e); q_tag.push_back(tag);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(input bit rd, input bit wr, input logic [2:0] s,
                    input logic [31:0] d, input bit src, input string tag);
    if (rd) push(1'b1, fexp(s, src), tag);
    else begin push(1'b0, 32'd0, tag); model_write(s, d); end
    @(negedge clk);
    rd_stb = rd; wr_stb = wr; prm_sel = s; prm_din = d; rd_from_ctl = src;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    wait_idle();
  endtask

  task automatic reconf();
    @(negedge clk); reconf_req = 1;
    @(negedge clk); reconf_req = 0;
    c_tmo = u_tmo; c_en = u_en; c_page = u_page; c_mode = u_mode; m_reason = 5'b00010;
  endtask

  // monitor: busy length and scoreboard compare at busy fall
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) bcnt++;
      else if (prev_busy) begin
        check("R2 busy length", bcnt, BC);
        if (q_rd.size() == 0) check("R4 unexpected completion", 1, 0);
        else begin
          if (q_rd[0]) check(q_tag[0], prm_dout, q_exp[0]);
          void'(q_rd.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end
        bcnt = 0;
      end
      prev_busy = busy;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    rst = 0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 dout after reset", prm_dout, 0);
    op(1, 0, 3'b010, 0, 1, "R1 ctl timeout zero");
    op(1, 0, 3'b100, 0, 0, "R1 upd page zero");
    op(1, 0, 3'b000, 0, 1, "R1 reason zero");
    // field writes
    op(0, 1, 3'b010, 32'hFFFF_FABC, 0, "R6 wr tmo");
    op(1, 0, 3'b010, 0, 0, "R6 upd timeout low 12 bits");
    op(1, 0, 3'b010, 0, 1, "R5 ctl timeout still zero");
    op(0, 1, 3'b011, 32'h3, 0, "R6 wr en");
    op(1, 0, 3'b011, 0, 0, "R6 enable bit0");
    op(0, 1, 3'b100, 32'h1234_5677, 0, "R7 wr page");
    op(1, 0, 3'b100, 0, 0, "R7 page low bits zero");
    op(0, 1, 3'b000, 32'h1F, 0, "R8 wr status");
    op(1, 0, 3'b000, 0, 0, "R8 status read-only");
    // illegal codes
    op(0, 1, 3'b001, 32'hFFFF_FFFF, 0, "R9 wr 001");
    op(0, 1, 3'b110, 32'hFFFF_FFFF, 0, "R9 wr 110");
    op(0, 1, 3'b111, 32'hFFFF_FFFF, 0, "R9 wr 111");
    op(1, 0, 3'b001, 0, 0, "R9 rd 001 zero");
    op(1, 0, 3'b110, 0, 1, "R9 rd 110 zero");
    op(1, 0, 3'b111, 0, 0, "R9 rd 111 zero");
    op(1, 0, 3'b010, 0, 0, "R9 timeout untouched");
    op(1, 0, 3'b100, 0, 0, "R9 page untouched");
    // R3: activity while busy
    push(1'b1, fexp(3'b011, 0), "R3 read survives mid-busy activity");
    @(negedge clk);
    rd_stb = 1; prm_sel = 3'b011; rd_from_ctl = 0;
    @(negedge clk);
    rd_stb = 0; wr_stb = 1; reconf_req = 1; prm_sel = 3'b010;
    prm_din = 32'hFFF; rd_from_ctl = 1;
    @(negedge clk);
    wr_stb = 0; reconf_req = 0; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    wait_idle();
    op(1, 0, 3'b010, 0, 0, "R3 upd timeout unchanged");
    op(1, 0, 3'b010, 0, 1, "R3 ctl timeout unchanged");
    op(1, 0, 3'b000, 0, 1, "R3 reason unchanged");
    // R12 both strobes
    op(1, 1, 3'b010, 32'h555, 0, "R12 read wins");
    op(1, 0, 3'b010, 0, 0, "R12 write dropped");
    // R11 reconfiguration
    reconf();
    op(1, 0, 3'b010, 0, 1, "R11 ctl timeout copied");
    op(1, 0, 3'b100, 0, 1, "R11 ctl page copied");
    op(1, 0, 3'b011, 0, 1, "R11 ctl enable copied");
    op(1, 0, 3'b000, 0, 0, "R8 reason core trigger");
    // to application mode
    op(0, 1, 3'b101, 32'h1, 0, "R10 wr mode");
    op(1, 0, 3'b101, 0, 0, "R6 upd mode");
    op(1, 0, 3'b101, 0, 1, "R5 ctl mode still factory");
    reconf();
    op(1, 0, 3'b101, 0, 1, "R11 ctl mode app");
    op(0, 1, 3'b010, 32'h123, 0, "R10 wr in app");
    op(1, 0, 3'b010, 0, 0, "R10 upd timeout locked");
    op(0, 1, 3'b100, 32'h0, 0, "R10 wr page in app");
    op(1, 0, 3'b100, 0, 0, "R10 upd page locked");
    repeat (3) @(negedge clk);
    check("R4 dout holds when idle", prm_dout, fexp(3'b100, 0));
    check("R2 scoreboard drained", q_rd.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule